// File: doc/BRIEF.md
# Low-Power Interrupt Wake Logic

This block merges a set of interrupt request sources into one prioritized request for the processor. It also decides whether that request is strong enough to bring the core out of a low-power state.

A source takes part in arbitration only when all of the following hold:
- its request line is high;
- the module that raised it has enabled it;
- the controller's own mask bit for that source is clear;
- software has programmed a non-zero level for it.

Among the sources that take part, the highest level wins. When two or more sources share that level, the lowest-numbered one supplies the vector index.

The whole path from the request lines to the level, vector and wake outputs is combinational. Wake therefore still works in stop mode, when every clock is halted. Wake is granted when the winning level is at or above the processor's current priority mask. Level 7 is non-maskable and always wakes. The low-power mode input has no effect: the block behaves the same in run, wait, doze and stop.

Software programs the mask register and the per-source levels through a small synchronous write port. Address 0 holds the mask. Addresses 1 to NUM_SRC hold the levels.

Top module: `lp_wake_top`

## Requirements
- R1: irqLevel, irqVector and wakeReq follow changes on srcReq, modEn and cpuMask with no clock edge, so they respond while the clock input is held constant.
- R2: Source i is counted only when all of these hold: srcReq[i]=1, modEn[i]=1, mask bit i=0, and its programmed level is non-zero. A source that fails any of these has no effect on the outputs.
- R3: irqLevel equals the largest programmed level among the counted sources, or 0 when no source is counted.
- R4: irqVector is the lowest source index among the counted sources at the level irqLevel. It is 0 when no source is counted.
- R5: wakeReq is 1 exactly when irqLevel is non-zero and irqLevel >= cpuMask (unsigned 3-bit compare), or when irqLevel is 7.
- R6: Level 7 always wakes: wakeReq is 1 whenever irqLevel is 7, even with cpuMask at 7.
- R7: lpMode (0 run, 1 wait, 2 doze, 3 stop) has no effect on any output.
- R8: While rstN is low, the mask register becomes all ones (every source masked) and every level becomes 0. Outputs stay 0 after reset until software programs the registers.
- R9: A write with regWrEn=1 takes effect at the next rising clk edge. Address 0 loads the mask from regWrData, where bit i=1 masks source i. Address k in 1..NUM_SRC loads the level of source k-1 from regWrData[2:0]. Writes to higher addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register write clock; may be stopped |
| rstN | input | 1 | Active-low reset of the mask and level registers |
| regWrEn | input | 1 | Register write strobe |
| regWrAddr | input | $clog2(NUM_SRC+1) | Write address: 0 selects the mask, k selects the level of source k-1 |
| regWrData | input | NUM_SRC | Write data |
| srcReq | input | NUM_SRC | Per-source request lines |
| modEn | input | NUM_SRC | Per-source enable from the originating module |
| cpuMask | input | 3 | Processor's current priority mask |
| lpMode | input | 2 | Current low-power mode |
| irqLevel | output | 3 | Level of the winning request; 0 when none |
| irqVector | output | $clog2(NUM_SRC) | Index of the winning source |
| wakeReq | output | 1 | Request to leave the low-power mode |

## Verification
The assertions check the following relations between inputs and outputs on every clock edge:
- the wake rule against cpuMask;
- the non-maskable behaviour of level 7;
- that a zero level gives no wake and a zero vector;
- that a winning vector always points at a source that is both requesting and module-enabled;
- the empty state right after reset.

Some behaviours need the bench's own register shadow and scenarios:
- that the outputs follow the inputs while the clock is frozen;
- that the mode input has no effect;
- the lowest-index rule on ties;
- that writes to out-of-range addresses are dropped.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam int LVL_W = 3;
  localparam logic [LVL_W-1:0] NMI_LVL = 3'd7;

  typedef enum logic [1:0] {
    LP_RUN  = 2'd0,
    LP_WAIT = 2'd1,
    LP_DOZE = 2'd2,
    LP_STOP = 2'd3
  } lpMode_e;

  // Strobes from write decode to the register file
  typedef struct packed {
    logic maskWe;
    logic lvlWe;
  } wrStrobes_t;

endpackage

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regWrAddr,
  input  logic [1:0]        lpMode,
  output wrStrobes_t        strobes,
  output logic [IDX_W-1:0]  lvlSel
);

  // Mode is deliberately not used: behaviour is identical in every mode
  logic unusedMode;
  assign unusedMode = ^lpMode;

  logic addrIsMask;
  logic addrIsLvl;

  assign addrIsMask = (regWrAddr == '0);
  assign addrIsLvl  = !addrIsMask && (regWrAddr <= ADDR_W'(NUM_SRC));

  always_comb begin
    strobes        = '0;
    strobes.maskWe = regWrEn && addrIsMask;
    strobes.lvlWe  = regWrEn && addrIsLvl;
  end

  assign lvlSel = IDX_W'(regWrAddr - ADDR_W'(1));

endmodule

// File: rtl/wake_dp.sv
module wake_dp
  import wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  wrStrobes_t         strobes,
  input  logic [IDX_W-1:0]   lvlSel,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] modEn,
  input  logic [LVL_W-1:0]   cpuMask,
  output logic [LVL_W-1:0]   irqLevel,
  output logic [IDX_W-1:0]   irqVector,
  output logic               wakeReq
);

  logic [NUM_SRC-1:0] maskReg;
  logic [LVL_W-1:0]   lvlReg [NUM_SRC];
  logic [NUM_SRC-1:0] live;

  // Mask register: all sources masked out of reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               maskReg <= '1;
    else if (strobes.maskWe) maskReg <= wrData;
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : gSrc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        lvlReg[g] <= '0;
      else if (strobes.lvlWe && (lvlSel == IDX_W'(g)))
        lvlReg[g] <= wrData[LVL_W-1:0];
    end

    // Purely combinational qualification, no flop on the request path
    assign live[g] = srcReq[g] & modEn[g] & ~maskReg[g] & (lvlReg[g] != '0);
  end

  // Downward scan with >= so the lowest index wins on equal levels
  logic [LVL_W-1:0] bestLvl;
  logic [IDX_W-1:0] bestIdx;

  always_comb begin
    bestLvl = '0;
    bestIdx = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (live[i] && (lvlReg[i] >= bestLvl)) begin
        bestLvl = lvlReg[i];
        bestIdx = IDX_W'(i);
      end
    end
  end

  assign irqLevel  = bestLvl;
  assign irqVector = bestIdx;
  assign wakeReq   = (bestLvl != '0) &&
                     ((bestLvl >= cpuMask) || (bestLvl == NMI_LVL));

endmodule

// File: rtl/lp_wake_top.sv
module lp_wake_top
  import wake_pkg::*;
#(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int ADDR_W = $clog2(NUM_SRC + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regWrAddr,
  input  logic [NUM_SRC-1:0] regWrData,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] modEn,
  input  logic [2:0]         cpuMask,
  input  logic [1:0]         lpMode,
  output logic [2:0]         irqLevel,
  output logic [IDX_W-1:0]   irqVector,
  output logic               wakeReq
);

  wrStrobes_t       strobes;
  logic [IDX_W-1:0] lvlSel;

  wake_ctrl #(.NUM_SRC(NUM_SRC)) uCtrl (
    .regWrEn   (regWrEn),
    .regWrAddr (regWrAddr),
    .lpMode    (lpMode),
    .strobes   (strobes),
    .lvlSel    (lvlSel)
  );

  wake_dp #(.NUM_SRC(NUM_SRC)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .lvlSel    (lvlSel),
    .wrData    (regWrData),
    .srcReq    (srcReq),
    .modEn     (modEn),
    .cpuMask   (cpuMask),
    .irqLevel  (irqLevel),
    .irqVector (irqVector),
    .wakeReq   (wakeReq)
  );

endmodule

// File: rtl/wake_chk.sv
module wake_chk #(
  parameter int NUM_SRC = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_SRC-1:0] srcReq,
  input logic [NUM_SRC-1:0] modEn,
  input logic [2:0]         cpuMask,
  input logic [2:0]         irqLevel,
  input logic [IDX_W-1:0]   irqVector,
  input logic               wakeReq
);

  p_wake_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> ((irqLevel != 3'd0) && ((irqLevel >= cpuMask) || (irqLevel == 3'd7))));

  p_wake_when_ok_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((irqLevel != 3'd0) && (irqLevel >= cpuMask)) |-> wakeReq);

  p_nmi_wakes_r6: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd7) |-> wakeReq);

  p_idle_vector_r4: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel == 3'd0) |-> (irqVector == '0 && !wakeReq));

  p_winner_live_r2: assert property (@(posedge clk) disable iff (!rstN)
    (irqLevel != 3'd0) |-> (srcReq[irqVector] && modEn[irqVector]));

  p_no_source_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((srcReq & modEn) == '0) |-> (irqLevel == 3'd0));

  p_reset_empty_r8: assert property (@(posedge clk)
    $rose(rstN) |-> (irqLevel == 3'd0 && !wakeReq));

endmodule

bind lp_wake_top wake_chk #(.NUM_SRC(NUM_SRC)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .srcReq    (srcReq),
  .modEn     (modEn),
  .cpuMask   (cpuMask),
  .irqLevel  (irqLevel),
  .irqVector (irqVector),
  .wakeReq   (wakeReq)
);

// File: tb/tb_lp_wake_top.sv
`timescale 1ns/1ps
module tb_lp_wake_top;

  localparam int N      = 8;
  localparam int IDX_W  = $clog2(N);
  localparam int ADDR_W = $clog2(N + 1);

  logic             clk = 1'b0;
  logic             clkRun = 1'b1;
  logic             rstN;
  logic             regWrEn;
  logic [ADDR_W-1:0] regWrAddr;
  logic [N-1:0]     regWrData;
  logic [N-1:0]     srcReq;
  logic [N-1:0]     modEn;
  logic [2:0]       cpuMask;
  logic [1:0]       lpMode;
  logic [2:0]       irqLevel;
  logic [IDX_W-1:0] irqVector;
  logic             wakeReq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [N-1:0] shMask;
  logic [2:0]   shLvl [N];

  lp_wake_top #(.NUM_SRC(N)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrAddr(regWrAddr),
    .regWrData(regWrData), .srcReq(srcReq), .modEn(modEn), .cpuMask(cpuMask),
    .lpMode(lpMode), .irqLevel(irqLevel), .irqVector(irqVector), .wakeReq(wakeReq)
  );

  always #2.5 if (clkRun) clk = ~clk;

  // Reference model of the requirements
  function automatic logic [2:0] expLevel();
    logic [2:0] best = 3'd0;
    for (int i = 0; i < N; i++)
      if (srcReq[i] && modEn[i] && !shMask[i] && shLvl[i] > best) best = shLvl[i];
    return best;
  endfunction

  function automatic logic [IDX_W-1:0] expVector();
    logic [2:0] lv = expLevel();
    if (lv == 3'd0) return '0;
    for (int i = 0; i < N; i++)
      if (srcReq[i] && modEn[i] && !shMask[i] && shLvl[i] == lv) return IDX_W'(i);
    return '0;
  endfunction

  function automatic logic expWake();
    logic [2:0] lv = expLevel();
    return (lv != 3'd0) && ((lv >= cpuMask) || (lv == 3'd7));
  endfunction

  task automatic checkAll(input string tag);
    logic [2:0] eL = expLevel();
    logic [IDX_W-1:0] eV = expVector();
    logic eW = expWake();
    checks++;
    if (irqLevel !== eL || irqVector !== eV || wakeReq !== eW) begin
      errors++;
      $display("FAIL %s: level/vector/wake actual %0d/%0d/%0b expected %0d/%0d/%0b",
               tag, irqLevel, irqVector, wakeReq, eL, eV, eW);
    end
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [N-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == '0) shMask = d;
    else if (a <= ADDR_W'(N)) shLvl[a - 1] = d[2:0];
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    rstN = 1'b0; regWrEn = 1'b0; regWrAddr = '0; regWrData = '0;
    srcReq = '1; modEn = '1; cpuMask = 3'd0; lpMode = 2'd0;
    shMask = '1;
    for (int i = 0; i < N; i++) shLvl[i] = 3'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1 checkAll("R8 reset state");

    // Levels programmed but mask still fully set
    writeReg(4'd1, 8'd3); writeReg(4'd2, 8'd5); writeReg(4'd3, 8'd5);
    writeReg(4'd4, 8'd7); writeReg(4'd5, 8'd1); writeReg(4'd6, 8'd0);
    writeReg(4'd7, 8'd2); writeReg(4'd8, 8'd5);
    #1 checkAll("R8 masked after reset");
    checks++;
    if (irqLevel !== 3'd0) begin
      errors++;
      $display("FAIL R9 masked level actual %0d expected 0", irqLevel);
    end

    writeReg(4'd0, 8'h00);
    srcReq = 8'b1000_0110; modEn = '1; cpuMask = 3'd0;
    #1 checkAll("R4 tie lowest index");
    checks++;
    if (irqVector !== 3'd1 || irqLevel !== 3'd5) begin
      errors++;
      $display("FAIL R4 tie actual %0d/%0d expected 5/1", irqLevel, irqVector);
    end

    modEn = 8'b1111_1101;
    #1 checkAll("R2 module enable off");
    writeReg(4'd0, 8'h04);
    #1 checkAll("R9 mask write");
    checks++;
    if (irqVector !== 3'd7) begin
      errors++;
      $display("FAIL R9 mask bit2 actual vec %0d expected 7", irqVector);
    end
    writeReg(4'd0, 8'h00); modEn = '1;

    srcReq = 8'b0000_0100; cpuMask = 3'd6;
    #1 checkAll("R5 below mask");
    cpuMask = 3'd5;
    #1 checkAll("R5 equal to mask");
    srcReq = 8'b0010_0000;
    #1 checkAll("R2 zero level");
    srcReq = 8'b0000_1001; cpuMask = 3'd7;
    #1 checkAll("R6 level 7 at mask 7");
    checks++;
    if (wakeReq !== 1'b1) begin
      errors++;
      $display("FAIL R6 wake actual %0b expected 1", wakeReq);
    end
    srcReq = 8'b0100_0001;
    #1 checkAll("R3 max level");

    // Ignored address
    writeReg(4'd12, 8'hff);
    srcReq = 8'hff; cpuMask = 3'd4;
    #1 checkAll("R9 out-of-range write ignored");

    // Mode independence
    srcReq = 8'b1000_0001; cpuMask = 3'd4;
    for (int m = 0; m < 4; m++) begin
      lpMode = 2'(m);
      #1 checkAll("R7 mode sweep");
    end

    // Freeze the clock low and enter stop mode
    @(negedge clk);
    clkRun = 1'b0;
    lpMode = 2'd3; cpuMask = 3'd6; srcReq = 8'b0000_0001;
    #10 checkAll("R1 stop mode low level");
    checks++;
    if (wakeReq !== 1'b0) begin
      errors++;
      $display("FAIL R1 stop no wake actual %0b expected 0", wakeReq);
    end
    srcReq = 8'b0000_1001;
    #10 checkAll("R1 stop mode wake");
    checks++;
    if (wakeReq !== 1'b1 || clk !== 1'b0) begin
      errors++;
      $display("FAIL R1 stop wake actual %0b expected 1", wakeReq);
    end
    clkRun = 1'b1;
    lpMode = 2'd0;

    // Constrained random phase
    for (int it = 0; it < 400; it++) begin
      if (($urandom % 6) == 0) begin
        int a = $urandom % 16;
        logic [N-1:0] d = (a == 0) ? N'($urandom & $urandom) : N'($urandom);
        writeReg(ADDR_W'(a), d);
      end
      @(negedge clk);
      srcReq  = N'($urandom);
      modEn   = N'($urandom | $urandom);
      cpuMask = 3'($urandom);
      lpMode  = 2'($urandom);
      #1 checkAll("R3 random");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule